// File: doc/BRIEF.md
# Fracturable six-input look-up table with mode forcing

The block is a six-input look-up table built as a binary multiplexer tree over a 64-bit truth table. Two mode bits sit in front of the two highest logic inputs. Each one drives a two-input OR gate, so a set mode bit holds that input at logic 1. With both mode bits clear the block is one LUT6. With the in[5] mode bit set it splits into two independent LUT5s. With both mode bits set it splits into two LUT4s. The split results are taken from intermediate stages of the tree.

All 66 configuration bits sit in one serial shift chain of flip-flops. The chain shifts one position on each rising clock edge while shift enable is high and holds otherwise. Loading a new configuration shifts the previous one out at the chain output, bit by bit, in the same order. The logic path from the inputs to the outputs is purely combinational.

Top module: `frac_lut6`

## Requirements
- R1: After reset is asserted (rst_ni low), the truth table is all zeros and the two mode bits are 1. All tap outputs are then 0 for every input, and chain_o reads 1.
- R2: While shift_en_i is high, each rising clock edge moves the chain by one place and captures chain_i. The chain stores its bits as cfg[65:0], with new bits entering at cfg[0], and chain_o shows cfg[65]. cfg[63:0] is the truth table (tt[i] = cfg[i]), cfg[64] is mode bit m0 and cfg[65] is mode bit m1. A full load therefore sends m1 first, then m0, then tt[63] down to tt[0].
- R3: While shift_en_i is low, chain_i is ignored. The stored configuration, chain_o and every output stay unchanged for unchanged logic inputs.
- R4: Let the effective input be e = in_i with e[4] = in_i[4] | m0 and e[5] = in_i[5] | m1. Then lut6_o = tt[e].
- R5: When m0 is 1, the value of in_i[4] has no effect on any output. When m1 is 1, the value of in_i[5] has no effect on any output.
- R6: lut5_o[0] = tt[{0, e[4:0]}] and lut5_o[1] = tt[{1, e[4:0]}]. These are the two stage-5 nodes.
- R7: lut4_o[0] = tt[{2'b10, e[3:0]}] and lut4_o[1] = tt[{2'b11, e[3:0]}]. These are stage-4 nodes 2 and 3.
- R8: During a load of 66 bits, chain_o presents the previous configuration before each shift edge: first the old m1, then the old m0, then the old tt[63] down to tt[0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Configuration chain clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the chain |
| shift_en_i | input | 1 | Chain shifts while high |
| chain_i | input | 1 | Serial configuration data in |
| chain_o | output | 1 | Serial configuration data out (last chain bit) |
| in_i | input | 6 | Logic inputs |
| lut4_o | output | 2 | Stage-4 taps (dual LUT4 results) |
| lut5_o | output | 2 | Stage-5 taps (dual LUT5 results) |
| lut6_o | output | 1 | Full tree output |

## Verification
The assertions are checked on every cycle. They cover the one-place shift into chain_o under shift enable and the hold of chain_o and the outputs while shift enable is low. They also check how the full output agrees with the upper LUT5 or upper LUT4 tap whenever the matching mode bit forces an input. The truth-table values at each tap can only be shown by the bench. It loads random and patterned tables under all four mode settings and sweeps all 64 input combinations. The bench also covers the reset contents, the order in which the old configuration leaves at chain_o, and that chain_i is ignored while held.

// File: rtl/frac_lut_pkg.sv
package frac_lut_pkg;
  parameter int unsigned LUT_K     = 6;
  parameter int unsigned MODE_W    = 2;
  localparam int unsigned TT_W     = 1 << LUT_K;
  localparam int unsigned CFG_W    = TT_W + MODE_W;
  // default: table cleared, both inputs forced (dual LUT4)
  localparam logic [CFG_W-1:0] CFG_RST = {{MODE_W{1'b1}}, {TT_W{1'b0}}};
endpackage

// File: rtl/frac_cfg_chain.sv
module frac_cfg_chain #(
  parameter int unsigned W = 66,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         chain_i,
  output logic         chain_o,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cfg_q <= RST_VAL;
    else if (shift_en_i) cfg_q <= {cfg_q[W-2:0], chain_i};
  end

  assign chain_o = cfg_q[W-1];
  assign cfg_o   = cfg_q;
endmodule

// File: rtl/frac_in_force.sv
module frac_in_force #(
  parameter int unsigned K = 6,
  parameter int unsigned M = 2
) (
  input  logic [K-1:0] in_i,
  input  logic [M-1:0] mode_i,
  output logic [K-1:0] eff_o
);
  for (genvar b = 0; b < K; b++) begin : g_bit
    if (b >= K - M) begin : g_or
      assign eff_o[b] = in_i[b] | mode_i[b-(K-M)];
    end else begin : g_pass
      assign eff_o[b] = in_i[b];
    end
  end
endmodule

// File: rtl/frac_mux_tree.sv
module frac_mux_tree #(
  parameter int unsigned K = 6
) (
  input  logic [(1<<K)-1:0] tt_i,
  input  logic [K-1:0]      sel_i,
  output logic [1:0]        tap4_o,
  output logic [1:0]        tap5_o,
  output logic              out_o
);
  localparam int unsigned N = 1 << K;

  for (genvar k = 0; k <= K; k++) begin : g_stg
    logic [(N>>k)-1:0] node;
    if (k == 0) begin : g_leaf
      assign node = tt_i;
    end else begin : g_mux
      for (genvar j = 0; j < (N >> k); j++) begin : g_node
        assign node[j] = sel_i[k-1] ? g_stg[k-1].node[2*j+1]
                                    : g_stg[k-1].node[2*j];
      end
    end
  end

  // upper pair of stage K-2 and both nodes of stage K-1
  assign tap4_o = g_stg[K-2].node[3:2];
  assign tap5_o = g_stg[K-1].node[1:0];
  assign out_o  = g_stg[K].node[0];
endmodule

// File: rtl/frac_lut6.sv
module frac_lut6
  import frac_lut_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             chain_i,
  output logic             chain_o,
  input  logic [LUT_K-1:0] in_i,
  output logic [1:0]       lut4_o,
  output logic [1:0]       lut5_o,
  output logic             lut6_o
);
  logic [CFG_W-1:0]  cfg_q;
  logic [MODE_W-1:0] mode_w;
  logic [TT_W-1:0]   tt_w;
  logic [LUT_K-1:0]  eff_w;

  assign tt_w   = cfg_q[TT_W-1:0];
  assign mode_w = cfg_q[CFG_W-1:TT_W];

  frac_cfg_chain #(.W(CFG_W), .RST_VAL(CFG_RST)) u_chain (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en_i),
    .chain_i   (chain_i),
    .chain_o   (chain_o),
    .cfg_o     (cfg_q)
  );

  frac_in_force #(.K(LUT_K), .M(MODE_W)) u_force (
    .in_i  (in_i),
    .mode_i(mode_w),
    .eff_o (eff_w)
  );

  frac_mux_tree #(.K(LUT_K)) u_tree (
    .tt_i  (tt_w),
    .sel_i (eff_w),
    .tap4_o(lut4_o),
    .tap5_o(lut5_o),
    .out_o (lut6_o)
  );
endmodule

// File: rtl/frac_lut6_chk.sv
module frac_lut6_chk
  import frac_lut_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             shift_en_i,
  input logic             chain_o,
  input logic [LUT_K-1:0] in_i,
  input logic [1:0]       lut4_o,
  input logic [1:0]       lut5_o,
  input logic             lut6_o,
  input logic [MODE_W-1:0] mode_w,
  input logic [CFG_W-1:0] cfg_q
);
  AST_SHIFT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> chain_o == $past(cfg_q[CFG_W-2])); // R2

  AST_HOLD_CHAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(chain_o)); // R3

  AST_HOLD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(shift_en_i) && $stable(in_i)) |-> ($stable(lut6_o) && $stable(lut5_o) && $stable(lut4_o))); // R3

  AST_FORCE_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_w[1] |-> lut6_o == lut5_o[1]); // R5

  AST_LUT5_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_w[1] && !in_i[5]) |-> lut6_o == lut5_o[0]); // R6

  AST_LUT4_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w == 2'b11) |-> lut6_o == lut4_o[1]); // R7
endmodule

bind frac_lut6 frac_lut6_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .shift_en_i(shift_en_i),
  .chain_o   (chain_o),
  .in_i      (in_i),
  .lut4_o    (lut4_o),
  .lut5_o    (lut5_o),
  .lut6_o    (lut6_o),
  .mode_w    (mode_w),
  .cfg_q     (cfg_q)
);

// File: tb/sim_frac_lut6.sv
`timescale 1ns/1ps
module sim_frac_lut6;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       shift_en_i = 1'b0;
  logic       chain_i = 1'b0;
  logic       chain_o;
  logic [5:0] in_i = '0;
  logic [1:0] lut4_o, lut5_o;
  logic       lut6_o;

  frac_lut6 u0 (.*);

  always #2.5 clk_i = ~clk_i;

  typedef struct packed {
    logic [5:0] in;
    logic [1:0] l4;
    logic [1:0] l5;
    logic       l6;
    logic [3:0] req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [63:0] m_tt = '0;
  logic [1:0]  m_md = 2'b11;

  function automatic exp_t model(input logic [5:0] v, input logic [3:0] r);
    exp_t x;
    logic [5:0] e;
    e = v | {m_md, 4'b0};
    x.in = v;
    x.l6 = m_tt[e];
    x.l5 = {m_tt[{1'b1, e[4:0]}], m_tt[{1'b0, e[4:0]}]};
    x.l4 = {m_tt[{2'b11, e[3:0]}], m_tt[{2'b10, e[3:0]}]};
    x.req = r;
    return x;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, expv);
    end
  endtask

  // driver: apply an input vector and push the expected result
  task automatic drive(input logic [5:0] v, input logic [3:0] r);
    @(negedge clk_i);
    in_i = v;
    exp_q.push_back(model(v, r));
  endtask

  task automatic sweep(input logic [3:0] r);
    for (int v = 0; v < 64; v++) drive(v[5:0], r);
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // monitor: outputs are settled since the preceding negedge
  always @(posedge clk_i) begin
    if (exp_q.size() > 0) begin
      exp_t x;
      x = exp_q.pop_front();
      chk(lut6_o == x.l6, $sformatf("R4/R%0d lut6 in=%0d", x.req, x.in), lut6_o, x.l6);
      chk(lut5_o == x.l5, $sformatf("R6 lut5 in=%0d", x.in), lut5_o, x.l5);
      chk(lut4_o == x.l4, $sformatf("R7 lut4 in=%0d", x.in), lut4_o, x.l4);
    end
  end

  // shift a full configuration; check the old one leaving at chain_o (R8, R2)
  task automatic load(input logic [63:0] tt, input logic [1:0] md);
    logic [65:0] nw, old;
    nw  = {md, tt};
    old = {m_md, m_tt};
    for (int i = 65; i >= 0; i--) begin
      @(negedge clk_i);
      shift_en_i = 1'b1;
      chain_i = nw[i];
      chk(chain_o == old[i], $sformatf("R8 out bit %0d", i), chain_o, old[i]);
    end
    @(negedge clk_i);
    shift_en_i = 1'b0;
    chk(chain_o == md[1], "R2 chain_o after load", chain_o, md[1]);
    m_tt = tt;
    m_md = md;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] t;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    chk(chain_o == 1'b1, "R1 chain_o reset", chain_o, 1);
    sweep(4'd1); // R1: default table zero, mode 11

    load({$urandom, $urandom}, 2'b00);
    sweep(4'd4);
    load({$urandom, $urandom}, 2'b10);
    sweep(4'd5);
    load({$urandom, $urandom}, 2'b01);
    sweep(4'd5);
    load({$urandom, $urandom}, 2'b11);
    sweep(4'd7);
    for (int i = 0; i < 64; i++) t[i] = ^i[5:0];
    load(t, 2'b00);
    sweep(4'd4);
    load(64'hFFFF_0000_F0F0_0F0F, 2'b10);
    sweep(4'd6);

    // R3: chain_i toggles with shift disabled; nothing changes
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      chain_i = ~chain_i;
      chk(chain_o == m_md[1], "R3 chain_o held", chain_o, m_md[1]);
    end
    sweep(4'd3);

    // R5: upper inputs toggled under forcing leave output unchanged
    load(64'h0123_4567_89AB_CDEF, 2'b11);
    for (int v = 0; v < 16; v++) begin
      drive({2'b00, v[3:0]}, 4'd5);
      drive({2'b11, v[3:0]}, 4'd5);
      drive({2'b01, v[3:0]}, 4'd5);
    end
    load({$urandom, $urandom}, 2'b00);
    sweep(4'd4);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule